// File: doc/BRIEF.md
# Time-Multiplexed Interrupt Level Requester

This block collects interrupt pending flags from groups of peripheral submodules and presents them to a shared bus interrupt structure. Each group has a pending register, an enable register and a 5-bit level register. A group raises one internal request when any of its pending bits is set on an enabled source. The level code of that group then picks one of eight request wires and one of four time-multiplex slots. Together these give 32 distinct interrupt levels on eight wires plus a two-bit slot phase.

A small slot sequencer steps through four named states, `SLOT_0` → `SLOT_1` → `SLOT_2` → `SLOT_3` → `SLOT_0`. It takes one transition on every clock and has no other transitions. Reset forces `SLOT_0`. The current state is driven on `irq_slot`. A group's request wire is driven only while the sequencer is in the slot that the group's level code names. Software sets up enables and levels through a simple word-wide register port. Pending bits are set by per-source event pulses and cleared by writing ones.

Group 0 serves submodules 15 to 0. Group 1 serves the next sixteen submodules.

Top module: `ilr_top`

## Requirements
- R1: After a synchronous reset, every pending, enable and level register reads zero, `irq_slot` is 0 and `irq_line` is all zero.
- R2: `irq_slot` advances by one on every clock and wraps from 3 to 0.
- R3: A group's request is the OR over all bits of (pending AND enable). Group g owns `src_evt[16g+15:16g]`.
- R4: In a level code, bits [4:2] select the request line and bits [1:0] select the slot. Line N is high only in a cycle where some requesting group has line field N and slot field equal to `irq_slot`.
- R5: When groups share a slot, `irq_line` is the bitwise OR of their decoded lines. Two groups on the same line and slot drive that single line, with no arbitration.
- R6: A high `src_evt` bit sets its pending bit at the next clock edge, and the bit stays set until it is cleared.
- R7: Writing to a pending register clears the bits written as one. If an event arrives on the same edge as the clear, the event wins and the bit stays set.
- R8: Enable registers are plain read/write. A pending bit whose enable is zero still latches and reads back, but it raises no request.
- R9: A level write takes effect from the cycle after the write edge. The request moves to its new line and slot without being dropped or doubled in any cycle.
- R10: The register map is: group g at base 4g, offset 0 pending, offset 1 enable, offset 2 level (zero-extended). Reads are combinational. Any other address reads zero, and a write to it changes nothing.
- R11: While no group has a request, `irq_line` stays all zero in every slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_evt | input | 32 | Per-source event pulses, one bit per submodule |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Combinational read data for `reg_addr` |
| irq_line | output | 8 | Request wires to the bus interrupt structure |
| irq_slot | output | 2 | Current time-multiplex slot |

## Verification
The hardest cases to reach from the ports are collisions that depend on phase. One is two groups meeting on the same line and slot. Another is a level rewrite or a write-one-to-clear that lands on the very edge where an event arrives or the targeted slot comes around. The stimulus reaches these by programming both groups onto one slot and then onto shared lines. It issues clears together with events on the same bit, and it rewrites levels during a running rotation. A long phase of random events, clears and level writes follows, so these collisions occur in every slot phase. Each cycle is compared against a behavioural model.

// File: rtl/ilr_pkg.sv
package ilr_pkg;
    localparam int LINE_SEL_W = 3;
    localparam int SLOT_SEL_W = 2;
    localparam int LEVEL_W    = LINE_SEL_W + SLOT_SEL_W;
    localparam int NUM_LINES  = 1 << LINE_SEL_W;
    localparam int GROUP_STRIDE = 4;

    localparam int OFF_PEND = 0;
    localparam int OFF_EN   = 1;
    localparam int OFF_LVL  = 2;

    typedef enum logic [SLOT_SEL_W-1:0] {
        SLOT_0 = 2'd0,
        SLOT_1 = 2'd1,
        SLOT_2 = 2'd2,
        SLOT_3 = 2'd3
    } slot_e;
endpackage

// File: rtl/ilr_slot_seq.sv
module ilr_slot_seq
    import ilr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    output logic [SLOT_SEL_W-1:0] slot_o
);
    slot_e state_q;
    slot_e state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= SLOT_0;
        else     state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            SLOT_0:  state_d = SLOT_1;
            SLOT_1:  state_d = SLOT_2;
            SLOT_2:  state_d = SLOT_3;
            SLOT_3:  state_d = SLOT_0;
            default: state_d = SLOT_0;
        endcase
    end

    always_comb begin
        unique case (state_q)
            SLOT_0:  slot_o = 2'd0;
            SLOT_1:  slot_o = 2'd1;
            SLOT_2:  slot_o = 2'd2;
            SLOT_3:  slot_o = 2'd3;
            default: slot_o = 2'd0;
        endcase
    end
endmodule

// File: rtl/ilr_group_regs.sv
module ilr_group_regs
    import ilr_pkg::*;
#(
    parameter int GW   = 16,
    parameter int AW   = 4,
    parameter int BASE = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [GW-1:0]      evt,
    input  logic               wr,
    input  logic [AW-1:0]      addr,
    input  logic [GW-1:0]      wdata,
    output logic [GW-1:0]      pend_o,
    output logic [LEVEL_W-1:0] lvl_o,
    output logic               req_o,
    output logic [GW-1:0]      rdata_o
);
    localparam logic [AW-1:0] A_PEND = AW'(BASE + OFF_PEND);
    localparam logic [AW-1:0] A_EN   = AW'(BASE + OFF_EN);
    localparam logic [AW-1:0] A_LVL  = AW'(BASE + OFF_LVL);

    logic [GW-1:0]      pend_q;
    logic [GW-1:0]      en_q;
    logic [LEVEL_W-1:0] lvl_q;
    logic               hit_pend;
    logic               hit_en;
    logic               hit_lvl;

    assign hit_pend = (addr == A_PEND);
    assign hit_en   = (addr == A_EN);
    assign hit_lvl  = (addr == A_LVL);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else if (wr && hit_pend) begin
            pend_q <= (pend_q & ~wdata) | evt;
        end else begin
            pend_q <= pend_q | evt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                en_q <= '0;
        else if (wr && hit_en)  en_q <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)                lvl_q <= '0;
        else if (wr && hit_lvl) lvl_q <= wdata[LEVEL_W-1:0];
    end

    assign req_o  = |(pend_q & en_q);
    assign pend_o = pend_q;
    assign lvl_o  = lvl_q;

    always_comb begin
        rdata_o = '0;
        if (hit_pend)     rdata_o = pend_q;
        else if (hit_en)  rdata_o = en_q;
        else if (hit_lvl) rdata_o = GW'(lvl_q);
    end
endmodule

// File: rtl/ilr_line_drive.sv
module ilr_line_drive
    import ilr_pkg::*;
#(
    parameter int NG = 2
) (
    input  logic [NG-1:0]         req,
    input  logic [NG*LEVEL_W-1:0] lvl_flat,
    input  logic [SLOT_SEL_W-1:0] slot,
    output logic [NUM_LINES-1:0]  line_o
);
    logic [NUM_LINES-1:0] grp_line [NG];

    for (genvar g = 0; g < NG; g++) begin : g_dec
        logic [LEVEL_W-1:0]    lvl_g;
        logic [LINE_SEL_W-1:0] line_sel;
        logic [SLOT_SEL_W-1:0] slot_sel;
        assign lvl_g    = lvl_flat[g*LEVEL_W +: LEVEL_W];
        assign line_sel = lvl_g[LEVEL_W-1:SLOT_SEL_W];
        assign slot_sel = lvl_g[SLOT_SEL_W-1:0];
        always_comb begin
            grp_line[g] = '0;
            if (req[g] && (slot_sel == slot)) grp_line[g][line_sel] = 1'b1;
        end
    end

    always_comb begin
        line_o = '0;
        for (int g = 0; g < NG; g++) line_o = line_o | grp_line[g];
    end
endmodule

// File: rtl/ilr_top.sv
module ilr_top
    import ilr_pkg::*;
#(
    parameter int NUM_GROUPS  = 2,
    parameter int GROUP_WIDTH = 16,
    parameter int ADDR_W      = 4
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NUM_GROUPS*GROUP_WIDTH-1:0] src_evt,
    input  logic                              reg_wr,
    input  logic [ADDR_W-1:0]                 reg_addr,
    input  logic [GROUP_WIDTH-1:0]            reg_wdata,
    output logic [GROUP_WIDTH-1:0]            reg_rdata,
    output logic [NUM_LINES-1:0]              irq_line,
    output logic [SLOT_SEL_W-1:0]             irq_slot
);
    localparam int SRC_W = NUM_GROUPS * GROUP_WIDTH;

    logic [NUM_GROUPS-1:0]         group_req;
    logic [NUM_GROUPS*LEVEL_W-1:0] lvl_flat;
    logic [SRC_W-1:0]              pend_flat;
    logic [GROUP_WIDTH-1:0]        grp_rdata [NUM_GROUPS];

    ilr_slot_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .slot_o (irq_slot)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        ilr_group_regs #(
            .GW   (GROUP_WIDTH),
            .AW   (ADDR_W),
            .BASE (g * GROUP_STRIDE)
        ) u_regs (
            .clk     (clk),
            .rst     (rst),
            .evt     (src_evt[g*GROUP_WIDTH +: GROUP_WIDTH]),
            .wr      (reg_wr),
            .addr    (reg_addr),
            .wdata   (reg_wdata),
            .pend_o  (pend_flat[g*GROUP_WIDTH +: GROUP_WIDTH]),
            .lvl_o   (lvl_flat[g*LEVEL_W +: LEVEL_W]),
            .req_o   (group_req[g]),
            .rdata_o (grp_rdata[g])
        );
    end

    always_comb begin
        reg_rdata = '0;
        for (int g = 0; g < NUM_GROUPS; g++) reg_rdata = reg_rdata | grp_rdata[g];
    end

    ilr_line_drive #(.NG(NUM_GROUPS)) u_drive (
        .req      (group_req),
        .lvl_flat (lvl_flat),
        .slot     (irq_slot),
        .line_o   (irq_line)
    );
endmodule

// File: rtl/ilr_checker.sv
module ilr_checker
    import ilr_pkg::*;
#(
    parameter int NG = 2,
    parameter int GW = 16,
    parameter int AW = 4
) (
    input logic                  clk,
    input logic                  rst,
    input logic [NG*GW-1:0]      src_evt,
    input logic                  reg_wr,
    input logic [AW-1:0]         reg_addr,
    input logic [GW-1:0]         reg_wdata,
    input logic [NUM_LINES-1:0]  irq_line,
    input logic [SLOT_SEL_W-1:0] irq_slot,
    input logic [NG-1:0]         group_req,
    input logic [NG*GW-1:0]      pend_flat
);
    a_r2_slot_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> irq_slot == $past(irq_slot) + 2'd1);

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        group_req == '0 |-> irq_line == '0);

    a_r4_line_needs_req: assert property (@(posedge clk) disable iff (rst)
        irq_line != '0 |-> group_req != '0);

    a_r5_line_bound: assert property (@(posedge clk) disable iff (rst)
        $countones(irq_line) <= NG);

    a_r6_evt_sets: assert property (@(posedge clk) disable iff (rst)
        src_evt != '0 |=> (pend_flat & $past(src_evt)) == $past(src_evt));

    a_r7_w1c_clears: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == '0 && src_evt[GW-1:0] == '0)
        |=> (pend_flat[GW-1:0] & $past(reg_wdata)) == '0);
endmodule

bind ilr_top ilr_checker #(
    .NG (NUM_GROUPS),
    .GW (GROUP_WIDTH),
    .AW (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .src_evt   (src_evt),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .irq_line  (irq_line),
    .irq_slot  (irq_slot),
    .group_req (group_req),
    .pend_flat (pend_flat)
);

// File: tb/tb_ilr_top.sv
module tb_ilr_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src_evt = '0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [7:0]  irq_line;
    logic [1:0]  irq_slot;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [15:0] m_pend [2];
    logic [15:0] m_en   [2];
    logic [4:0]  m_lvl  [2];
    int          m_slot;

    always #5 clk = ~clk;

    ilr_top dut (
        .clk(clk), .rst(rst), .src_evt(src_evt), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_line(irq_line), .irq_slot(irq_slot)
    );

    function automatic logic [7:0] exp_line();
        logic [7:0] l = '0;
        for (int g = 0; g < 2; g++)
            if ((m_pend[g] & m_en[g]) != 0 && int'(m_lvl[g][1:0]) == m_slot)
                l[m_lvl[g][4:2]] = 1'b1;
        return l;
    endfunction

    function automatic logic [15:0] exp_rdata(input logic [3:0] a);
        for (int g = 0; g < 2; g++) begin
            if (int'(a) == g*4)     return m_pend[g];
            if (int'(a) == g*4 + 1) return m_en[g];
            if (int'(a) == g*4 + 2) return {11'b0, m_lvl[g]};
        end
        return '0;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_edge(input logic [31:0] e, input logic w,
                              input logic [3:0] a, input logic [15:0] d);
        if (rst) begin
            for (int g = 0; g < 2; g++) begin m_pend[g] = '0; m_en[g] = '0; m_lvl[g] = '0; end
            m_slot = 0;
        end else begin
            m_slot = (m_slot + 1) % 4;
            for (int g = 0; g < 2; g++) begin
                if (w && int'(a) == g*4) m_pend[g] = m_pend[g] & ~d;
                m_pend[g] = m_pend[g] | e[g*16 +: 16];
                if (w && int'(a) == g*4 + 1) m_en[g] = d;
                if (w && int'(a) == g*4 + 2) m_lvl[g] = d[4:0];
            end
        end
    endtask

    // One clock: drive after negedge, update model at posedge, compare at next negedge
    task automatic cyc(input string tag, input logic [31:0] e, input logic w,
                       input logic [3:0] a, input logic [15:0] d);
        src_evt = e; reg_wr = w; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        model_edge(e, w, a, d);
        @(negedge clk);
        check({tag, " R2 slot"}, 32'(irq_slot), 32'(m_slot));
        check({tag, " R4 line"}, 32'(irq_line), 32'(exp_line()));
        check({tag, " R10 rdata"}, 32'(reg_rdata), 32'(exp_rdata(a)));
    endtask

    task automatic idle(input string tag, input int n, input logic [3:0] a);
        for (int i = 0; i < n; i++) cyc(tag, '0, 1'b0, a, '0);
    endtask

    task automatic wr(input string tag, input logic [3:0] a, input logic [15:0] d);
        cyc(tag, '0, 1'b1, a, d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog R2 actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int hits;
        @(negedge clk);
        cyc("R1 reset", '0, 1'b0, 4'd0, '0);
        cyc("R1 reset", '0, 1'b0, 4'd0, '0);
        rst = 1'b0;
        for (int a = 0; a < 8; a++) begin
            cyc("R1 readback", '0, 1'b0, 4'(a), '0);
            check("R1 zero after reset", 32'(reg_rdata), 32'h0);
        end
        idle("R11 idle", 8, 4'd0);

        // group 0: line 5 slot 2
        wr("R8 enable", 4'd1, 16'hFFFF);
        wr("R4 level", 4'd2, 16'd22);
        cyc("R6 event", 32'h0000_0008, 1'b0, 4'd0, '0);
        check("R6 pending set", 32'(reg_rdata), 32'h8);
        for (int r = 0; r < 3; r++) begin
            hits = 0;
            for (int i = 0; i < 4; i++) begin
                idle("R4 rotate", 1, 4'd0);
                if (irq_line == 8'h20) begin
                    hits++;
                    check("R4 slot match", 32'(irq_slot), 32'd2);
                end else check("R4 off slot quiet", 32'(irq_line), 32'h0);
            end
            check("R4 one hit per rotation", 32'(hits), 32'd1);
        end

        // W1C
        wr("R7 clear", 4'd0, 16'h0008);
        check("R7 cleared", 32'(reg_rdata), 32'h0);
        idle("R11 quiet after clear", 8, 4'd0);

        // R8: group1 event without enable
        cyc("R8 latch", 32'h0010_0000, 1'b0, 4'd4, '0);
        check("R8 disabled latches", 32'(reg_rdata), 32'h10);
        hits = 0;
        for (int i = 0; i < 4; i++) begin
            idle("R8 no req", 1, 4'd4);
            if (irq_line != 0) hits++;
        end
        check("R8 disabled raises nothing", 32'(hits), 32'd0);

        // R5: both groups same line and slot
        cyc("R6 event g0", 32'h0000_0001, 1'b0, 4'd0, '0);
        wr("R9 lvl1", 4'd6, 16'd22);
        wr("R8 en1", 4'd5, 16'h0010);
        hits = 0;
        for (int i = 0; i < 4; i++) begin
            idle("R5 shared", 1, 4'd6);
            if (irq_line != 0) begin
                hits++;
                check("R5 shared single line", 32'(irq_line), 32'h20);
            end
        end
        check("R5 shared one hit", 32'(hits), 32'd1);
        wr("R9 lvl1 line1", 4'd6, 16'd6);
        idle("R5 two lines", 8, 4'd6);
        wr("R9 lvl1 slot0", 4'd6, 16'd4);
        idle("R9 moved", 8, 4'd6);

        // R7: event and clear same edge
        cyc("R7 evt wins", 32'h0000_0001, 1'b1, 4'd0, 16'h0001);
        check("R7 event beats clear", 32'(reg_rdata), 32'h1);

        // R10 unmapped writes
        wr("R10 unmapped", 4'd3, 16'hFFFF);
        wr("R10 unmapped", 4'd7, 16'hFFFF);
        wr("R10 unmapped", 4'd12, 16'hFFFF);
        check("R10 unmapped reads zero", 32'(reg_rdata), 32'h0);
        idle("R10 state kept", 1, 4'd1);
        check("R10 en0 unchanged", 32'(reg_rdata), 32'hFFFF);
        idle("R10 state kept", 1, 4'd6);
        check("R10 lvl1 unchanged", 32'(reg_rdata), 32'd4);

        // random mix, R3 and R9 across all phases
        for (int i = 0; i < 600; i++) begin
            logic [31:0] e;
            logic [3:0] a;
            logic w;
            logic [15:0] d;
            e = (($urandom % 6) == 0) ? (32'd1 << ($urandom % 32)) : 32'd0;
            w = (($urandom % 4) == 0);
            a = 4'($urandom % 10);
            d = 16'($urandom);
            if (a == 4'd0 || a == 4'd4) d = d & 16'($urandom);
            cyc("R3 R9 random", e, w, a, d);
        end

        wr("R11 clr0", 4'd0, 16'hFFFF);
        wr("R11 clr1", 4'd4, 16'hFFFF);
        hits = 0;
        for (int i = 0; i < 8; i++) begin
            idle("R11 final idle", 1, 4'd0);
            if (irq_line != 0) hits++;
        end
        check("R11 all idle no line", 32'(hits), 32'd0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule